// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents one request to the processor. Each request has a priority level and a vector. Every source owns a programmable level byte. A zero level turns the source off. A nonzero level turns it on and also sets how urgent it is. A source takes part in arbitration only when its line or its force bit is high, its level is nonzero and its mask bit is clear. The selector picks the eligible source with the largest level. When two sources share the largest level, the higher-numbered source wins.

The winner's level and vector are held in registers that drive the processor. The vector is the source number plus 64. When no source is eligible, the level is 0 and the vector is the fixed idle value 24. Software uses a byte-addressed register port with 32-bit data. Through it, software can read the raw request lines, read and write the two mask halves, write the level bytes, send one-byte commands that set or clear a single mask bit or all mask bits, and read the current vector from the software acknowledge location.

Top module: `prio_intc`

## Requirements
- R1: A source is eligible only when (request line OR force bit) is 1, its level byte is nonzero and its mask bit is 0. While every mask bit is 1, the output level is 0.
- R2: A write to address 0x40+n stores data[7:0] as the level of source n, and a read of that address returns the stored byte zero-extended. A stored zero removes source n from arbitration.
- R3: Among the eligible sources, the one with the largest level wins. On equal levels, the higher source number wins.
- R4: For a winner n, the output level is the level byte of n and the output vector is n+64. With no eligible source, the level is 0 and the vector is 24.
- R5: After reset, all mask bits are 1, all level bytes and force bits are 0, the output level is 0 and the output vector is 24.
- R6: Reads of 0x00 and 0x04 return request lines 63:32 and 31:0. Writes to these two addresses change nothing.
- R7: Address 0x08 reads and writes mask bits 63:32. Address 0x0C reads and writes mask bits 31:0.
- R8: A write to 0x1C sets every mask bit if data[6]=1. Otherwise it sets only the mask bit whose index is data[5:0].
- R9: A write to 0x1D clears every mask bit if data[6]=1. Otherwise it clears only the mask bit whose index is data[5:0].
- R10: A read of 0xE0 returns the output vector as it stood at the request edge.
- R11: Reads of 0x10 and 0x14 return force bits 63:32 and 31:0, which have no write path and stay zero. Reads of undefined addresses, including 0xE1 to 0xE7, return 0. Writes to undefined addresses change nothing.
- R12: A change on a request line shows on the outputs after the next clock edge. A register write shows on the outputs one edge after the write edge. Read data is valid in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 64 | Level-sensitive request lines |
| reg_vld_i | input | 1 | Register access strobe, one cycle |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_lvl_o | output | 8 | Level of the winning source, 0 when idle |
| irq_vec_o | output | 8 | Vector of the winning source, 24 when idle |

## Verification
The bench goes after ties between equal levels. A selector that kept the first match instead of the last one would output the lower source's vector. It also writes a zero level to a source that is requesting. A design that keeps a separate enable would keep that source winning. The single-bit and all-bits mask commands are driven with the all-bit both set and clear. An index decode that ignored data[6] would touch only one mask bit, leaving the rest wrong. Writes to the request-line addresses and to unused addresses are read back, which catches any stray register update. Output timing is sampled right after a write edge, which catches a design whose outputs are early or late by one cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // Register port byte addresses (decoded by the block)
   localparam logic [7:0] A_PEND_HI = 8'h00;
   localparam logic [7:0] A_PEND_LO = 8'h04;
   localparam logic [7:0] A_MASK_HI = 8'h08;
   localparam logic [7:0] A_MASK_LO = 8'h0C;
   localparam logic [7:0] A_FRC_HI  = 8'h10;
   localparam logic [7:0] A_FRC_LO  = 8'h14;
   localparam logic [7:0] A_MSET    = 8'h1C;
   localparam logic [7:0] A_MCLR    = 8'h1D;
   localparam logic [7:0] A_LVL0    = 8'h40;
   localparam logic [7:0] A_SWACK   = 8'hE0;

   typedef enum logic [1:0] {
      MOP_NONE,
      MOP_SET,
      MOP_CLR
   } mask_op_e;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
   import pic_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned LVL_W   = 8,
   parameter int unsigned VEC_W   = 8,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic                     wr_i,
   input  logic [7:0]               addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [NUM_SRC-1:0]       pend_i,
   input  logic [VEC_W-1:0]         vec_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic [NUM_SRC-1:0]       mask_o,
   output logic [NUM_SRC-1:0]       force_o,
   output logic [NUM_SRC*LVL_W-1:0] lvl_o
);
   localparam int unsigned ALL_BIT = IDX_W;

   if (NUM_SRC != 2 * DATA_W) begin : g_bad_split
      $error("pic_regfile: NUM_SRC must equal two data words");
   end
   if (LVL_W > DATA_W) begin : g_bad_lvl
      $error("pic_regfile: LVL_W wider than data");
   end
   if (ALL_BIT >= DATA_W) begin : g_bad_cmd
      $error("pic_regfile: command field does not fit data");
   end

   logic [NUM_SRC-1:0] mask_q, frc_q;
   logic [LVL_W-1:0]   lvl_q [NUM_SRC];
   logic               wen, ren;
   logic               in_lvl;
   logic [IDX_W-1:0]   lidx;
   logic [7:0]         loff;
   mask_op_e           mop;
   logic [DATA_W-1:0]  rd_d;

   assign wen    = vld_i &  wr_i;
   assign ren    = vld_i & ~wr_i;
   assign loff   = addr_i - A_LVL0;
   assign in_lvl = (addr_i >= A_LVL0) && ({24'd0, loff} < NUM_SRC);
   assign lidx   = loff[IDX_W-1:0];

   always_comb begin
      mop = MOP_NONE;
      if (wen && addr_i == A_MSET) mop = MOP_SET;
      if (wen && addr_i == A_MCLR) mop = MOP_CLR;
   end

   // Mask register: halves and byte commands
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (wen && addr_i == A_MASK_HI) begin
         mask_q[NUM_SRC-1:DATA_W] <= wdata_i;
      end else if (wen && addr_i == A_MASK_LO) begin
         mask_q[DATA_W-1:0] <= wdata_i;
      end else if (mop == MOP_SET) begin
         if (wdata_i[ALL_BIT]) mask_q <= '1;
         else                  mask_q[wdata_i[IDX_W-1:0]] <= 1'b1;
      end else if (mop == MOP_CLR) begin
         if (wdata_i[ALL_BIT]) mask_q <= '0;
         else                  mask_q[wdata_i[IDX_W-1:0]] <= 1'b0;
      end
   end

   // Force register has no write path on this port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frc_q <= '0;
      else        frc_q <= frc_q;
   end

   // Level bytes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
      end else if (wen && in_lvl) begin
         lvl_q[lidx] <= wdata_i[LVL_W-1:0];
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl_out
      assign lvl_o[g*LVL_W +: LVL_W] = lvl_q[g];
   end

   // Read mux
   always_comb begin
      rd_d = '0;
      if (in_lvl) begin
         rd_d[LVL_W-1:0] = lvl_q[lidx];
      end else begin
         unique case (addr_i)
            A_PEND_HI: rd_d = pend_i[NUM_SRC-1:DATA_W];
            A_PEND_LO: rd_d = pend_i[DATA_W-1:0];
            A_MASK_HI: rd_d = mask_q[NUM_SRC-1:DATA_W];
            A_MASK_LO: rd_d = mask_q[DATA_W-1:0];
            A_FRC_HI:  rd_d = frc_q[NUM_SRC-1:DATA_W];
            A_FRC_LO:  rd_d = frc_q[DATA_W-1:0];
            A_SWACK:   rd_d[VEC_W-1:0] = vec_i;
            default:   rd_d = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata_o <= '0;
      else if (ren) rdata_o <= rd_d;
   end

   assign mask_o  = mask_q;
   assign force_o = frc_q;

   a_r5_reset_mask: assert property (@(posedge clk)
      !rst_n |=> (mask_q == '1));
   a_r8_set_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && addr_i == A_MSET && wdata_i[ALL_BIT]) |=> (mask_q == '1));
   a_r9_clr_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && addr_i == A_MCLR && wdata_i[ALL_BIT]) |=> (mask_q == '0));
   a_r11_force_stays: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (frc_q == '0));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int unsigned NUM_SRC  = 64,
   parameter int unsigned LVL_W    = 8,
   parameter bit          ARB_TREE = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]       act_i,
   input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
   output logic                     win_vld_o,
   output logic [IDX_W-1:0]         win_idx_o,
   output logic [LVL_W-1:0]         win_lvl_o
);
   if ((1 << IDX_W) != NUM_SRC) begin : g_bad_n
      $error("pic_arbiter: NUM_SRC must be a power of two");
   end

   if (ARB_TREE) begin : g_tree
      localparam int unsigned NODES = 2 * NUM_SRC - 1;
      logic             nv [NODES];
      logic [LVL_W-1:0] nl [NODES];
      logic [IDX_W-1:0] ni [NODES];

      for (genvar s = 0; s < NUM_SRC; s++) begin : g_leaf
         assign nv[NUM_SRC-1+s] = act_i[s];
         assign nl[NUM_SRC-1+s] = lvl_i[s*LVL_W +: LVL_W];
         assign ni[NUM_SRC-1+s] = IDX_W'(s);
      end
      // Upper child is the higher-numbered range; it wins ties
      for (genvar k = 0; k < NUM_SRC - 1; k++) begin : g_node
         logic take_hi;
         assign take_hi = nv[2*k+2] && (!nv[2*k+1] || nl[2*k+2] >= nl[2*k+1]);
         assign nv[k] = nv[2*k+1] | nv[2*k+2];
         assign nl[k] = take_hi ? nl[2*k+2] : nl[2*k+1];
         assign ni[k] = take_hi ? ni[2*k+2] : ni[2*k+1];
      end
      assign win_vld_o = nv[0];
      assign win_idx_o = ni[0];
      assign win_lvl_o = nl[0];
   end else begin : g_scan
      always_comb begin
         win_vld_o = 1'b0;
         win_idx_o = '0;
         win_lvl_o = '0;
         for (int s = 0; s < NUM_SRC; s++) begin
            if (act_i[s] && lvl_i[s*LVL_W +: LVL_W] >= win_lvl_o) begin
               win_vld_o = 1'b1;
               win_idx_o = IDX_W'(s);
               win_lvl_o = lvl_i[s*LVL_W +: LVL_W];
            end
         end
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
   parameter int unsigned NUM_SRC  = 64,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LVL_W    = 8,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_BASE = 64,
   parameter int unsigned VEC_IDLE = 24,
   parameter bit          ARB_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       irq_i,
   input  logic              reg_vld_i,
   input  logic              reg_wr_i,
   input  logic [7:0]        reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic [7:0]        irq_lvl_o,
   output logic [7:0]        irq_vec_o
);
   localparam int unsigned IDX_W = $clog2(NUM_SRC);

   if (NUM_SRC != 64 || DATA_W != 32 || LVL_W != 8 || VEC_W != 8) begin : g_bad_port
      $error("prio_intc: port widths fixed at 64/32/8/8");
   end
   if (VEC_BASE + NUM_SRC > (1 << VEC_W) || VEC_IDLE >= (1 << VEC_W)) begin : g_bad_vec
      $error("prio_intc: vector range exceeds VEC_W");
   end

   logic [NUM_SRC-1:0]       mask, frc, en, act;
   logic [NUM_SRC*LVL_W-1:0] lvl_flat;
   logic                     win_vld;
   logic [IDX_W-1:0]         win_idx;
   logic [LVL_W-1:0]         win_lvl;
   logic [LVL_W-1:0]         lvl_q;
   logic [VEC_W-1:0]         vec_q;

   pic_regfile #(
      .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .LVL_W(LVL_W), .VEC_W(VEC_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .vld_i(reg_vld_i), .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .pend_i(irq_i), .vec_i(vec_q),
      .rdata_o(reg_rdata_o), .mask_o(mask), .force_o(frc), .lvl_o(lvl_flat)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
      assign en[s] = |lvl_flat[s*LVL_W +: LVL_W];
   end

   assign act = (irq_i | frc) & en & ~mask;

   pic_arbiter #(
      .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ARB_TREE(ARB_TREE)
   ) u_arb (
      .act_i(act), .lvl_i(lvl_flat),
      .win_vld_o(win_vld), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         vec_q <= VEC_W'(VEC_IDLE);
      end else if (win_vld) begin
         lvl_q <= win_lvl;
         vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
      end else begin
         lvl_q <= '0;
         vec_q <= VEC_W'(VEC_IDLE);
      end
   end

   assign irq_lvl_o = lvl_q;
   assign irq_vec_o = vec_q;

   a_r1_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> act[win_idx]);
   a_r1_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask) |=> (irq_lvl_o == '0));
   a_r3_winner_level: assert property (@(posedge clk) disable iff (!rst_n)
      win_vld |-> (win_lvl == lvl_flat[win_idx*LVL_W +: LVL_W]) && (win_lvl != '0));
   a_r4_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lvl_o == '0) |-> (irq_vec_o == VEC_W'(VEC_IDLE)));
   a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_lvl_o != '0) |-> (irq_vec_o >= VEC_W'(VEC_BASE)));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq = '0;
   logic        vld = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  lvl_o, vec_o;

   int unsigned nvec = 0, nerr = 0;
   logic [63:0] m_mask;
   logic [7:0]  m_lvl [64];

   always #10 clk = ~clk;

   prio_intc dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq),
      .reg_vld_i(vld), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_lvl_o(lvl_o), .irq_vec_o(vec_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference scan: upward over sources, replace on >= (R1, R3, R4)
   function automatic logic [15:0] model_out();
      logic [7:0] bl = 0;
      logic [7:0] bv = 8'd24;
      for (int s = 0; s < 64; s++) begin
         if (irq[s] && m_lvl[s] != 0 && !m_mask[s] && m_lvl[s] >= bl) begin
            bl = m_lvl[s];
            bv = 8'(s + 64);
         end
      end
      return {bl, bv};
   endfunction

   function automatic logic [31:0] model_rd(logic [7:0] a);
      if (a >= 8'h40 && a < 8'h80) return {24'd0, m_lvl[a - 8'h40]};
      case (a)
         8'h00: return irq[63:32];
         8'h04: return irq[31:0];
         8'h08: return m_mask[63:32];
         8'h0C: return m_mask[31:0];
         8'hE0: return {24'd0, model_out() & 16'h00FF};
         default: return 32'd0;
      endcase
   endfunction

   task automatic wreg(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      vld = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      vld = 1'b0; wr = 1'b0;
      if (a >= 8'h40 && a < 8'h80) m_lvl[a - 8'h40] = d[7:0];
      else if (a == 8'h08) m_mask[63:32] = d;
      else if (a == 8'h0C) m_mask[31:0] = d;
      else if (a == 8'h1C) begin
         if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
      end else if (a == 8'h1D) begin
         if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
      end
   endtask

   task automatic rreg(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      vld = 1'b1; wr = 1'b0; addr = a;
      @(posedge clk);
      @(negedge clk);
      vld = 1'b0;
      d = rdata;
   endtask

   task automatic settle_check(string req);
      logic [15:0] e;
      @(posedge clk);
      @(negedge clk);
      e = model_out();
      check({req, " level"}, {24'd0, lvl_o}, {24'd0, e[15:8]});
      check({req, " vector"}, {24'd0, vec_o}, {24'd0, e[7:0]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  a;
      void'($urandom(32'd20240517));
      m_mask = '1;
      for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R5 reset state
      check("R5 idle level", {24'd0, lvl_o}, 32'd0);
      check("R5 idle vector", {24'd0, vec_o}, 32'd24);
      rreg(8'h08, d); check("R5 mask hi", d, 32'hFFFF_FFFF);
      rreg(8'h0C, d); check("R5 mask lo", d, 32'hFFFF_FFFF);
      rreg(8'h5A, d); check("R5 level byte", d, 32'd0);

      // R9 clear all, R1 no level -> idle
      wreg(8'h1D, 32'h40);
      rreg(8'h0C, d); check("R9 clear all lo", d, 32'd0);
      rreg(8'h08, d); check("R9 clear all hi", d, 32'd0);
      @(negedge clk); irq = 64'h0000_0000_0000_0008;
      settle_check("R1 enabled-off source");

      // R12 write latency
      @(negedge clk);
      vld = 1'b1; wr = 1'b1; addr = 8'h43; wdata = 32'h5;
      @(posedge clk); @(negedge clk);
      vld = 1'b0; wr = 1'b0; m_lvl[3] = 8'd5;
      check("R12 not yet after write edge", {24'd0, lvl_o}, 32'd0);
      @(posedge clk); @(negedge clk);
      check("R12 level after next edge", {24'd0, lvl_o}, 32'd5);
      check("R4 vector n+64", {24'd0, vec_o}, 32'd67);

      // R12 irq latency: drop line, one edge later idle
      @(negedge clk); irq = '0;
      @(posedge clk); @(negedge clk);
      check("R12 irq fall one edge", {24'd0, vec_o}, 32'd24);

      // R3 tie toward higher number
      wreg(8'h45, 32'h3); wreg(8'h49, 32'h3);
      @(negedge clk); irq = 64'h0000_0000_0000_0220;
      settle_check("R3 tie");
      check("R3 tie picks 9", {24'd0, vec_o}, 32'd73);
      wreg(8'h45, 32'h4);
      settle_check("R3 higher level");
      check("R3 level 4 wins", {24'd0, vec_o}, 32'd69);
      // R2 zero level disables
      wreg(8'h45, 32'h0);
      settle_check("R2 zero disables");
      check("R2 falls to 9", {24'd0, vec_o}, 32'd73);
      rreg(8'h45, d); check("R2 readback zero", d, 32'd0);
      rreg(8'h49, d); check("R2 readback", d, 32'd3);

      // R8 single set masks source 9
      wreg(8'h1C, 32'h09);
      settle_check("R8 single set");
      rreg(8'h0C, d); check("R8 bit 9 only", d, 32'h0000_0200);
      wreg(8'h1D, 32'h09);
      wreg(8'h1C, 32'h40);
      rreg(8'h08, d); check("R8 set all hi", d, 32'hFFFF_FFFF);
      settle_check("R1 all masked");
      check("R1 masked level", {24'd0, lvl_o}, 32'd0);
      wreg(8'h1D, 32'h7F);
      rreg(8'h08, d); check("R9 all-bit wins over index", d, 32'd0);

      // R7 mask halves
      wreg(8'h08, 32'hA5A5_0001);
      rreg(8'h08, d); check("R7 mask hi rw", d, 32'hA5A5_0001);
      rreg(8'h0C, d); check("R7 mask lo untouched", d, 32'd0);
      wreg(8'h08, 32'h0);

      // R6 pending reads, writes ignored
      @(negedge clk); irq = 64'h8000_0001_0000_0220;
      wreg(8'h00, 32'h1234_5678); wreg(8'h04, 32'hFFFF_FFFF);
      rreg(8'h00, d); check("R6 pend hi", d, 32'h8000_0001);
      rreg(8'h04, d); check("R6 pend lo", d, 32'h0000_0220);
      settle_check("R6 write no effect");

      // R10 software acknowledge
      rreg(8'hE0, d); check("R10 swack", d, 32'd73);

      // R11 force and undefined
      rreg(8'h10, d); check("R11 force hi", d, 32'd0);
      rreg(8'h14, d); check("R11 force lo", d, 32'd0);
      rreg(8'hE3, d); check("R11 level ack range", d, 32'd0);
      wreg(8'h30, 32'hFFFF_FFFF); wreg(8'hE1, 32'hFFFF_FFFF);
      rreg(8'h0C, d); check("R11 undefined write lo", d, 32'd0);
      rreg(8'h30, d); check("R11 undefined read", d, 32'd0);
      settle_check("R11 undefined write outputs");

      // Constrained random mix
      for (int it = 0; it < 600; it++) begin
         int unsigned op = $urandom % 7;
         case (op)
            0, 1: begin
               int unsigned v = $urandom % 8;
               if ($urandom % 4 == 0) v = 0;
               wreg(8'(8'h40 + ($urandom % 64)), v);
            end
            2: wreg(($urandom % 2) ? 8'h08 : 8'h0C, $urandom & $urandom);
            3: wreg(8'h1C, ($urandom % 16 == 0) ? 32'h40 : ($urandom % 64));
            4: wreg(8'h1D, ($urandom % 8 == 0) ? 32'h40 : ($urandom % 64));
            5: begin
               @(negedge clk);
               irq = {$urandom, $urandom} & {$urandom, $urandom};
            end
            default: begin
               case ($urandom % 7)
                  0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h0C;
                  4: a = 8'hE0;  5: a = 8'h14;
                  default: a = 8'(8'h40 + ($urandom % 64));
               endcase
               rreg(a, d);
               check("R2 R6 R7 R10 R11 readback", d, model_rd(a));
            end
         endcase
         settle_check("R1 R3 R4 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule